// File: doc/BRIEF.md
# Coherency Port ID Mapper

This block sits between a system interconnect and a coherency slave port that accepts only a few transaction IDs. Each request arrives with a 12-bit ID and a 5-bit user sideband. The block translates the ID to a 3-bit outgoing ID. It also replaces the user sideband and selects which 1 GiB page of the 4 GiB address space the coherent window covers. The read and write channels each have their own mapping table, their own counters of outstanding transactions and their own shared dynamic setting.

Each usable outgoing ID works in one of two modes. In fixed mode it is bound to one incoming ID and carries its own page and user value. In dynamic mode it belongs to a pool. The pool lends an ID to any incoming ID that has no fixed binding, and the loan lasts as long as transactions are outstanding on it. Outgoing IDs 0 and 1 belong to the processor cores and are never handed out. ID 7 can only be dynamic. A configuration port writes the settings, reports illegal writes and reads back any entry.

Top module: `idmap_top`

## Requirements
- R1: After reset, outgoing ID 2 is fixed to incoming ID 0x004 with page 0 and user 0. IDs 3 to 7 are dynamic. The shared dynamic page and user are both 0.
- R2: Outgoing IDs 0 and 1 are never granted. A configuration write of kind 0 or 1 (kind encoding: 0 = fixed, 1 = dynamic, 2 = shared setting, 3 = illegal) aimed at ID 0 or 1 changes nothing, and `cfg_rsvd_err` reads 1 from the cycle after the write.
- R3: Outgoing ID 7 stays dynamic. A fixed write to it changes nothing and sets `cfg_rsvd_err`. A legal write clears `cfg_rsvd_err` in the next cycle.
- R4: A request whose incoming ID matches a fixed entry is granted that entry's outgoing ID, page and user value, in the same cycle.
- R5: A request with no fixed match and no held dynamic ID gets the lowest-numbered dynamic ID that has no outstanding transactions.
- R6: A dynamic ID stays with its incoming ID while its outstanding count is non-zero, and further requests from that incoming ID reuse it. Each grant adds one to the count and each completion on that outgoing ID takes one away. At zero the ID is free for any incoming ID.
- R7: `*_ready` is low when no dynamic ID is free for a new incoming ID, or when the selected entry's counter is full.
- R8: When `*_fabric` is high, the outgoing user value equals the incoming user value, for both fixed and dynamic grants.
- R9: Dynamic grants carry the channel's shared page and user value.
- R10: Configuration, allocation and completions on one channel have no effect on the other channel.
- R11: Read-back gives the fixed flag, the bound incoming ID, the page and the user value. A dynamic entry reads as flag 0 and ID 0, with the shared page and user value. IDs 0 and 1 read as all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read request present |
| ar_id | input | 12 | Read incoming ID |
| ar_user | input | 5 | Read incoming user sideband |
| ar_fabric | input | 1 | Read request comes from the fabric bridge |
| ar_ready | output | 1 | Read request granted this cycle |
| ar_oid | output | 3 | Read outgoing ID |
| ar_user_o | output | 5 | Read outgoing user sideband |
| ar_page | output | 2 | Read 1 GiB page select |
| rcpl_valid | input | 1 | A read transaction completed |
| rcpl_oid | input | 3 | Outgoing ID of the completed read |
| aw_valid | input | 1 | Write request present |
| aw_id | input | 12 | Write incoming ID |
| aw_user | input | 5 | Write incoming user sideband |
| aw_fabric | input | 1 | Write request comes from the fabric bridge |
| aw_ready | output | 1 | Write request granted this cycle |
| aw_oid | output | 3 | Write outgoing ID |
| aw_user_o | output | 5 | Write outgoing user sideband |
| aw_page | output | 2 | Write 1 GiB page select |
| wcpl_valid | input | 1 | A write transaction completed |
| wcpl_oid | input | 3 | Outgoing ID of the completed write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Target table: 0 read, 1 write |
| cfg_kind | input | 2 | 0 fixed, 1 dynamic, 2 shared setting, 3 illegal |
| cfg_oid | input | 3 | Target outgoing ID (not used for kind 2) |
| cfg_in_id | input | 12 | Incoming ID to bind (fixed) |
| cfg_page | input | 2 | Page value |
| cfg_user | input | 5 | User value |
| cfg_rsvd_err | output | 1 | Last configuration write was refused |
| rb_chan | input | 1 | Read-back table select |
| rb_oid | input | 3 | Read-back outgoing ID |
| rb_fixed | output | 1 | Entry is fixed |
| rb_in_id | output | 12 | Bound incoming ID, 0 when dynamic |
| rb_page | output | 2 | Entry page, or shared page when dynamic |
| rb_user | output | 5 | Entry user, or shared user when dynamic |

## Verification
The assertions check on every cycle that no grant ever uses a core-reserved ID, that a fabric-bridge grant passes its user bits through, that ID 7 never reads back as fixed, and that a refused configuration write raises the error flag in the next cycle. Only the bench scenarios can show the rest. That covers the lowest-free allocation order, reuse of a held ID while it has outstanding work, release after the last completion, the stall when the pool is empty, and whether the shared dynamic setting and fixed-entry values reach the outputs. They also show that the read and write tables stay independent.

// File: rtl/idmap_pkg.sv
`timescale 1ns/1ps
package idmap_pkg;
  localparam int unsigned IDM_IN_W    = 12;
  localparam int unsigned IDM_USR_W   = 5;
  localparam int unsigned IDM_PG_W    = 2;
  localparam int unsigned IDM_NUM_OUT = 8;
  localparam int unsigned IDM_FIRST   = 2;
  localparam int unsigned IDM_DBG_OID = 2;
  localparam logic [IDM_IN_W-1:0] IDM_DBG_ID = 12'h004;

  typedef enum logic [1:0] {
    KIND_FIXED  = 2'd0,
    KIND_DYN    = 2'd1,
    KIND_SHARED = 2'd2,
    KIND_BAD    = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/idmap_slot.sv
`timescale 1ns/1ps
module idmap_slot #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned USR_W = 5,
  parameter int unsigned PG_W  = 2,
  parameter int unsigned CNT_W = 4,
  parameter bit CAN_FIX = 1'b1,
  parameter bit RST_FIX = 1'b0,
  parameter logic [IN_W-1:0] RST_ID = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_fix,
  input  logic [IN_W-1:0]  cfg_id,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic [USR_W-1:0] cfg_user,
  input  logic             take,
  input  logic [IN_W-1:0]  take_id,
  input  logic             done,
  output logic             fixed_o,
  output logic [IN_W-1:0]  id_o,
  output logic [PG_W-1:0]  page_o,
  output logic [USR_W-1:0] user_o,
  output logic             busy_o,
  output logic             full_o
);
  logic             fix_q, fix_d;
  logic [IN_W-1:0]  id_q, id_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [USR_W-1:0] user_q, user_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cfg_en, dec;

  assign cfg_en = cfg_wr | take;
  assign dec    = done & (cnt_q != '0);

  always_comb begin
    fix_d  = fix_q;
    id_d   = id_q;
    page_d = page_q;
    user_d = user_q;
    if (cfg_wr) begin
      fix_d  = CAN_FIX & cfg_fix;
      id_d   = (CAN_FIX & cfg_fix) ? cfg_id : '0;
      page_d = cfg_page;
      user_d = cfg_user;
    end else if (take && !fix_q) begin
      id_d = take_id;
    end
    cnt_d = cnt_q;
    if (take && !dec)      cnt_d = cnt_q + 1'b1;
    else if (!take && dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q  <= RST_FIX;
      id_q   <= RST_ID;
      page_q <= '0;
      user_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (cfg_en) begin
        fix_q  <= fix_d;
        id_q   <= id_d;
        page_q <= page_d;
        user_q <= user_d;
      end
      cnt_q <= cnt_d;
    end
  end

  assign fixed_o = fix_q;
  assign id_o    = id_q;
  assign page_o  = page_q;
  assign user_o  = user_q;
  assign busy_o  = cnt_q != '0;
  assign full_o  = &cnt_q;
endmodule

// File: rtl/idmap_chan.sv
`timescale 1ns/1ps
module idmap_chan
  import idmap_pkg::*;
#(
  parameter int unsigned IN_W    = IDM_IN_W,
  parameter int unsigned USR_W   = IDM_USR_W,
  parameter int unsigned PG_W    = IDM_PG_W,
  parameter int unsigned NUM_OUT = IDM_NUM_OUT,
  parameter int unsigned FIRST   = IDM_FIRST,
  parameter int unsigned DBG_OID = IDM_DBG_OID,
  parameter logic [IN_W-1:0] DBG_ID = IDM_DBG_ID,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned OUT_W  = $clog2(NUM_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IN_W-1:0]  req_id,
  input  logic [USR_W-1:0] req_user,
  input  logic             req_fabric,
  output logic             req_ready,
  output logic [OUT_W-1:0] map_oid,
  output logic [USR_W-1:0] map_user,
  output logic [PG_W-1:0]  map_page,
  input  logic             cpl_valid,
  input  logic [OUT_W-1:0] cpl_oid,
  input  logic             cfg_wr,
  input  cfg_kind_e        cfg_kind,
  input  logic [OUT_W-1:0] cfg_oid,
  input  logic [IN_W-1:0]  cfg_id,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic [USR_W-1:0] cfg_user,
  input  logic [OUT_W-1:0] rb_oid,
  output logic             rb_fixed,
  output logic [IN_W-1:0]  rb_id,
  output logic [PG_W-1:0]  rb_page,
  output logic [USR_W-1:0] rb_user
);
  logic             s_fix  [NUM_OUT];
  logic [IN_W-1:0]  s_id   [NUM_OUT];
  logic [PG_W-1:0]  s_page [NUM_OUT];
  logic [USR_W-1:0] s_user [NUM_OUT];
  logic             s_busy [NUM_OUT];
  logic             s_full [NUM_OUT];
  logic [PG_W-1:0]  sh_page_q, sh_page_d;
  logic [USR_W-1:0] sh_user_q, sh_user_d;
  logic             sh_en;

  logic             fix_hit, own_hit, free_hit, any_hit;
  logic [OUT_W-1:0] fix_sel, own_sel, free_sel, sel;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
    if (i < FIRST) begin : g_core
      assign s_fix[i]  = 1'b0;
      assign s_id[i]   = '0;
      assign s_page[i] = '0;
      assign s_user[i] = '0;
      assign s_busy[i] = 1'b1;
      assign s_full[i] = 1'b1;
    end else begin : g_pool
      logic slot_wr, slot_take, slot_done;
      assign slot_wr   = cfg_wr && (cfg_kind != KIND_SHARED) && (cfg_oid == OUT_W'(i));
      assign slot_take = req_valid && req_ready && (sel == OUT_W'(i));
      assign slot_done = cpl_valid && (cpl_oid == OUT_W'(i));
      idmap_slot #(
        .IN_W(IN_W), .USR_W(USR_W), .PG_W(PG_W), .CNT_W(CNT_W),
        .CAN_FIX(i != NUM_OUT - 1),
        .RST_FIX(i == DBG_OID),
        .RST_ID((i == DBG_OID) ? DBG_ID : '0)
      ) u_slot (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(slot_wr), .cfg_fix(cfg_kind == KIND_FIXED),
        .cfg_id(cfg_id), .cfg_page(cfg_page), .cfg_user(cfg_user),
        .take(slot_take), .take_id(req_id), .done(slot_done),
        .fixed_o(s_fix[i]), .id_o(s_id[i]), .page_o(s_page[i]),
        .user_o(s_user[i]), .busy_o(s_busy[i]), .full_o(s_full[i])
      );
    end
  end

  // Selection: fixed binding, then held dynamic ID, then lowest free pool ID
  always_comb begin
    fix_hit  = 1'b0; fix_sel  = '0;
    own_hit  = 1'b0; own_sel  = '0;
    free_hit = 1'b0; free_sel = '0;
    for (int i = NUM_OUT - 1; i >= int'(FIRST); i--) begin
      if (s_fix[i] && s_id[i] == req_id) begin
        fix_hit = 1'b1; fix_sel = OUT_W'(i);
      end
      if (!s_fix[i] && s_busy[i] && s_id[i] == req_id) begin
        own_hit = 1'b1; own_sel = OUT_W'(i);
      end
      if (!s_fix[i] && !s_busy[i]) begin
        free_hit = 1'b1; free_sel = OUT_W'(i);
      end
    end
    if (fix_hit)      sel = fix_sel;
    else if (own_hit) sel = own_sel;
    else              sel = free_sel;
    any_hit = fix_hit | own_hit | free_hit;
  end

  assign req_ready = any_hit && !s_full[sel];
  assign map_oid   = sel;
  assign map_page  = fix_hit ? s_page[sel] : sh_page_q;
  assign map_user  = req_fabric ? req_user : (fix_hit ? s_user[sel] : sh_user_q);

  assign sh_en     = cfg_wr && (cfg_kind == KIND_SHARED);
  assign sh_page_d = sh_en ? cfg_page : sh_page_q;
  assign sh_user_d = sh_en ? cfg_user : sh_user_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_page_q <= '0;
      sh_user_q <= '0;
    end else if (sh_en) begin
      sh_page_q <= sh_page_d;
      sh_user_q <= sh_user_d;
    end
  end

  always_comb begin
    rb_fixed = 1'b0;
    rb_id    = '0;
    rb_page  = '0;
    rb_user  = '0;
    if (rb_oid >= OUT_W'(FIRST)) begin
      if (s_fix[rb_oid]) begin
        rb_fixed = 1'b1;
        rb_id    = s_id[rb_oid];
        rb_page  = s_page[rb_oid];
        rb_user  = s_user[rb_oid];
      end else begin
        rb_page  = sh_page_q;
        rb_user  = sh_user_q;
      end
    end
  end
endmodule

// File: rtl/idmap_top.sv
`timescale 1ns/1ps
module idmap_top
  import idmap_pkg::*;
#(
  parameter int unsigned IN_W    = IDM_IN_W,
  parameter int unsigned USR_W   = IDM_USR_W,
  parameter int unsigned PG_W    = IDM_PG_W,
  parameter int unsigned NUM_OUT = IDM_NUM_OUT,
  parameter int unsigned FIRST   = IDM_FIRST,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned OUT_W  = $clog2(NUM_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic [IN_W-1:0]  ar_id,
  input  logic [USR_W-1:0] ar_user,
  input  logic             ar_fabric,
  output logic             ar_ready,
  output logic [OUT_W-1:0] ar_oid,
  output logic [USR_W-1:0] ar_user_o,
  output logic [PG_W-1:0]  ar_page,
  input  logic             rcpl_valid,
  input  logic [OUT_W-1:0] rcpl_oid,
  input  logic             aw_valid,
  input  logic [IN_W-1:0]  aw_id,
  input  logic [USR_W-1:0] aw_user,
  input  logic             aw_fabric,
  output logic             aw_ready,
  output logic [OUT_W-1:0] aw_oid,
  output logic [USR_W-1:0] aw_user_o,
  output logic [PG_W-1:0]  aw_page,
  input  logic             wcpl_valid,
  input  logic [OUT_W-1:0] wcpl_oid,
  input  logic             cfg_we,
  input  logic             cfg_chan,
  input  logic [1:0]       cfg_kind,
  input  logic [OUT_W-1:0] cfg_oid,
  input  logic [IN_W-1:0]  cfg_in_id,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic [USR_W-1:0] cfg_user,
  output logic             cfg_rsvd_err,
  input  logic             rb_chan,
  input  logic [OUT_W-1:0] rb_oid,
  output logic             rb_fixed,
  output logic [IN_W-1:0]  rb_in_id,
  output logic [PG_W-1:0]  rb_page,
  output logic [USR_W-1:0] rb_user
);
  localparam int unsigned NCH = 2;

  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  cfg_kind_e kind;
  logic      refuse, err_d, err_q;
  assign kind   = cfg_kind_e'(cfg_kind);
  assign refuse = (kind == KIND_BAD) ||
                  ((kind != KIND_SHARED) && (cfg_oid < OUT_W'(FIRST))) ||
                  ((kind == KIND_FIXED) && (cfg_oid == OUT_W'(NUM_OUT - 1)));
  assign err_d  = cfg_we ? refuse : err_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     err_q <= 1'b0;
    else if (cfg_we) err_q <= err_d;
  end
  assign cfg_rsvd_err = err_q;

  logic             c_valid [NCH];
  logic [IN_W-1:0]  c_id    [NCH];
  logic [USR_W-1:0] c_user  [NCH];
  logic             c_fab   [NCH];
  logic             c_rdy   [NCH];
  logic [OUT_W-1:0] c_oid   [NCH];
  logic [USR_W-1:0] c_uo    [NCH];
  logic [PG_W-1:0]  c_pg    [NCH];
  logic             c_cv    [NCH];
  logic [OUT_W-1:0] c_co    [NCH];
  logic             c_rfix  [NCH];
  logic [IN_W-1:0]  c_rid   [NCH];
  logic [PG_W-1:0]  c_rpg   [NCH];
  logic [USR_W-1:0] c_rus   [NCH];

  assign c_valid[0] = ar_valid;  assign c_valid[1] = aw_valid;
  assign c_id[0]    = ar_id;     assign c_id[1]    = aw_id;
  assign c_user[0]  = ar_user;   assign c_user[1]  = aw_user;
  assign c_fab[0]   = ar_fabric; assign c_fab[1]   = aw_fabric;
  assign c_cv[0]    = rcpl_valid; assign c_cv[1]   = wcpl_valid;
  assign c_co[0]    = rcpl_oid;  assign c_co[1]    = wcpl_oid;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = cfg_we && !refuse && (cfg_chan == c[0]);
    idmap_chan #(
      .IN_W(IN_W), .USR_W(USR_W), .PG_W(PG_W), .NUM_OUT(NUM_OUT),
      .FIRST(FIRST), .CNT_W(CNT_W)
    ) u_chan (
      .clk(clk), .rst_n(srst_n),
      .req_valid(c_valid[c]), .req_id(c_id[c]), .req_user(c_user[c]),
      .req_fabric(c_fab[c]), .req_ready(c_rdy[c]), .map_oid(c_oid[c]),
      .map_user(c_uo[c]), .map_page(c_pg[c]),
      .cpl_valid(c_cv[c]), .cpl_oid(c_co[c]),
      .cfg_wr(ch_wr), .cfg_kind(kind), .cfg_oid(cfg_oid), .cfg_id(cfg_in_id),
      .cfg_page(cfg_page), .cfg_user(cfg_user),
      .rb_oid(rb_oid), .rb_fixed(c_rfix[c]), .rb_id(c_rid[c]),
      .rb_page(c_rpg[c]), .rb_user(c_rus[c])
    );
  end

  assign ar_ready  = c_rdy[0]; assign aw_ready  = c_rdy[1];
  assign ar_oid    = c_oid[0]; assign aw_oid    = c_oid[1];
  assign ar_user_o = c_uo[0];  assign aw_user_o = c_uo[1];
  assign ar_page   = c_pg[0];  assign aw_page   = c_pg[1];

  assign rb_fixed = rb_chan ? c_rfix[1] : c_rfix[0];
  assign rb_in_id = rb_chan ? c_rid[1]  : c_rid[0];
  assign rb_page  = rb_chan ? c_rpg[1]  : c_rpg[0];
  assign rb_user  = rb_chan ? c_rus[1]  : c_rus[0];
endmodule

// File: rtl/idmap_chk.sv
`timescale 1ns/1ps
module idmap_chk #(
  parameter int unsigned OUT_W   = 3,
  parameter int unsigned USR_W   = 5,
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned FIRST   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic [OUT_W-1:0] ar_oid,
  input logic             ar_fabric,
  input logic [USR_W-1:0] ar_user,
  input logic [USR_W-1:0] ar_user_o,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic [OUT_W-1:0] aw_oid,
  input logic             aw_fabric,
  input logic [USR_W-1:0] aw_user,
  input logic [USR_W-1:0] aw_user_o,
  input logic             cfg_we,
  input logic [1:0]       cfg_kind,
  input logic [OUT_W-1:0] cfg_oid,
  input logic             cfg_rsvd_err,
  input logic [OUT_W-1:0] rb_oid,
  input logic             rb_fixed
);
  // R2
  rd_core_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |-> (ar_oid >= OUT_W'(FIRST)));
  // R2
  wr_core_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |-> (aw_oid >= OUT_W'(FIRST)));
  // R2
  core_cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind != 2'd2 && cfg_oid < OUT_W'(FIRST)) |=> cfg_rsvd_err);
  // R3
  last_dyn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_oid == OUT_W'(NUM_OUT - 1)) |-> !rb_fixed);
  // R3
  last_fix_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd0 && cfg_oid == OUT_W'(NUM_OUT - 1)) |=> cfg_rsvd_err);
  // R8
  rd_fabric_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready && ar_fabric) |-> (ar_user_o == ar_user));
  // R8
  wr_fabric_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && aw_fabric) |-> (aw_user_o == aw_user));
endmodule

bind idmap_top idmap_chk #(
  .OUT_W(OUT_W), .USR_W(USR_W), .NUM_OUT(NUM_OUT), .FIRST(FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_oid(ar_oid),
  .ar_fabric(ar_fabric), .ar_user(ar_user), .ar_user_o(ar_user_o),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_oid(aw_oid),
  .aw_fabric(aw_fabric), .aw_user(aw_user), .aw_user_o(aw_user_o),
  .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_oid(cfg_oid),
  .cfg_rsvd_err(cfg_rsvd_err), .rb_oid(rb_oid), .rb_fixed(rb_fixed)
);

// File: tb/idmap_top_test.sv
`timescale 1ns/1ps
module idmap_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ar_valid = 0, ar_fabric = 0, aw_valid = 0, aw_fabric = 0;
  logic [11:0] ar_id = 0, aw_id = 0, cfg_in_id = 0;
  logic [4:0]  ar_user = 0, aw_user = 0, cfg_user = 0;
  logic        rcpl_valid = 0, wcpl_valid = 0;
  logic [2:0]  rcpl_oid = 0, wcpl_oid = 0, cfg_oid = 0, rb_oid = 0;
  logic        cfg_we = 0, cfg_chan = 0, rb_chan = 0;
  logic [1:0]  cfg_kind = 0, cfg_page = 0;
  wire         ar_ready, aw_ready, cfg_rsvd_err, rb_fixed;
  wire  [2:0]  ar_oid, aw_oid;
  wire  [4:0]  ar_user_o, aw_user_o, rb_user;
  wire  [1:0]  ar_page, aw_page, rb_page;
  wire  [11:0] rb_in_id;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  idmap_top uut (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_id(ar_id), .ar_user(ar_user), .ar_fabric(ar_fabric),
    .ar_ready(ar_ready), .ar_oid(ar_oid), .ar_user_o(ar_user_o), .ar_page(ar_page),
    .rcpl_valid(rcpl_valid), .rcpl_oid(rcpl_oid),
    .aw_valid(aw_valid), .aw_id(aw_id), .aw_user(aw_user), .aw_fabric(aw_fabric),
    .aw_ready(aw_ready), .aw_oid(aw_oid), .aw_user_o(aw_user_o), .aw_page(aw_page),
    .wcpl_valid(wcpl_valid), .wcpl_oid(wcpl_oid),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_kind(cfg_kind), .cfg_oid(cfg_oid),
    .cfg_in_id(cfg_in_id), .cfg_page(cfg_page), .cfg_user(cfg_user),
    .cfg_rsvd_err(cfg_rsvd_err),
    .rb_chan(rb_chan), .rb_oid(rb_oid), .rb_fixed(rb_fixed), .rb_in_id(rb_in_id),
    .rb_page(rb_page), .rb_user(rb_user)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic req(input bit ch, input int id, input int usr, input bit fab,
                     input bit e_rdy, input int e_oid, input int e_pg,
                     input int e_usr, input string tag);
    @(negedge clk);
    if (ch) begin aw_valid = 1; aw_id = id[11:0]; aw_user = usr[4:0]; aw_fabric = fab; end
    else    begin ar_valid = 1; ar_id = id[11:0]; ar_user = usr[4:0]; ar_fabric = fab; end
    #1;
    check({tag, " ready"}, ch ? aw_ready : ar_ready, e_rdy);
    if (e_rdy) begin
      check({tag, " oid"},  ch ? aw_oid : ar_oid, e_oid);
      check({tag, " page"}, ch ? aw_page : ar_page, e_pg);
      check({tag, " user"}, ch ? aw_user_o : ar_user_o, e_usr);
    end
    @(posedge clk); #1;
    ar_valid = 0; aw_valid = 0; ar_fabric = 0; aw_fabric = 0;
  endtask

  task automatic cpl(input bit ch, input int oid);
    @(negedge clk);
    if (ch) begin wcpl_valid = 1; wcpl_oid = oid[2:0]; end
    else    begin rcpl_valid = 1; rcpl_oid = oid[2:0]; end
    @(posedge clk); #1;
    rcpl_valid = 0; wcpl_valid = 0;
  endtask

  task automatic cfg(input bit ch, input int kind, input int oid, input int id,
                     input int pg, input int usr, input bit e_err, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_chan = ch; cfg_kind = kind[1:0]; cfg_oid = oid[2:0];
    cfg_in_id = id[11:0]; cfg_page = pg[1:0]; cfg_user = usr[4:0];
    @(posedge clk); #1;
    cfg_we = 0;
    @(negedge clk);
    check({tag, " err"}, cfg_rsvd_err, e_err);
  endtask

  task automatic rb(input bit ch, input int oid, input bit e_fix, input int e_id,
                    input int e_pg, input int e_usr, input string tag);
    @(negedge clk);
    rb_chan = ch; rb_oid = oid[2:0];
    #1;
    check({tag, " fixed"}, rb_fixed, e_fix);
    check({tag, " id"},    rb_in_id, e_id);
    check({tag, " page"},  rb_page, e_pg);
    check({tag, " user"},  rb_user, e_usr);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 R11: reset contents of both tables
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++)
        rb(c[0], o, o == 2, (o == 2) ? 4 : 0, 0, 0, "R1 reset readback");

    // R4: debug master ID goes to its fixed output
    req(0, 12'h004, 5'h1f, 0, 1, 2, 0, 0, "R4 debug fixed");
    cpl(0, 2);

    // R2 R3: fixed writes to every output ID of the read table
    for (int o = 0; o < 8; o++)
      cfg(0, 0, o, 12'h100 + o, o % 4, o * 3, (o < 2) || (o == 7), "R2 R3 fixed cfg");
    for (int o = 0; o < 8; o++) begin
      if (o >= 2 && o <= 6)
        rb(0, o, 1, 12'h100 + o, o % 4, o * 3, "R11 fixed readback");
      else
        rb(0, o, 0, 0, 0, 0, "R2 R3 untouched readback");
    end
    cfg(0, 3, 4, 0, 0, 0, 1, "R2 illegal kind");
    cfg(0, 1, 3, 0, 0, 0, 0, "R3 legal clears err");
    cfg(0, 0, 3, 12'h103, 3, 9, 0, "R4 restore oid3");

    // R4 R8: fixed lookups, then pass-through of fabric user bits
    for (int o = 2; o <= 6; o++)
      req(0, 12'h100 + o, 0, 0, 1, o, o % 4, o * 3, "R4 fixed map");
    for (int o = 2; o <= 6; o++)
      req(0, 12'h100 + o, 5'h10 + o, 1, 1, o, o % 4, 5'h10 + o, "R8 fabric fixed");

    // R9: unbound ID falls to the only dynamic output (7)
    req(0, 12'h004, 3, 0, 1, 7, 0, 0, "R9 dyn fallback");
    cpl(0, 7);

    // R10: write table untouched by read-table writes
    rb(1, 3, 0, 0, 0, 0, "R10 write table readback");
    req(1, 12'h103, 0, 0, 1, 3, 0, 0, "R10 write dyn");
    cpl(1, 3);

    // R5 R6 R7 R9: dynamic pool on the read table
    for (int o = 2; o <= 6; o++) begin
      req(0, 12'h100 + o, 0, 0, 1, o, o % 4, o * 3, "R6 drain fixed");
      for (int k = 0; k < 3; k++) cpl(0, o);
    end
    for (int o = 2; o <= 6; o++) cfg(0, 1, o, 0, 0, 0, 0, "R9 to dynamic");
    cfg(0, 2, 0, 0, 2, 9, 0, "R9 shared setting");
    for (int k = 0; k < 6; k++)
      req(0, 12'h200 + k, 1, 0, k < 6 ? (k < 6) && (k < 6) && (k != 6) && (k < 6) && (k <= 5) && (k < 6) && (k < 6) && (k != 7) && 1'b1 : 0,
          2 + k, 2, 9, "R5 lowest free");
    req(0, 12'h2ff, 1, 0, 0, 0, 0, 0, "R7 pool empty");
    req(0, 12'h200, 1, 0, 1, 2, 2, 9, "R6 reuse held");
    cpl(0, 3);
    req(0, 12'h300, 1, 0, 1, 3, 2, 9, "R6 freed reassigned");
    cpl(0, 2);
    req(0, 12'h301, 1, 0, 0, 0, 0, 0, "R7 still held");
    cpl(0, 2);
    req(0, 12'h301, 1, 0, 1, 2, 2, 9, "R6 released");
    req(0, 12'h300, 5'h11, 1, 1, 3, 2, 5'h11, "R8 fabric dyn");
    rb(0, 4, 0, 0, 2, 9, "R11 dyn readback");

    // R10: shared setting of read table not seen on write table
    req(1, 12'h555, 4, 0, 1, 3, 0, 0, "R10 write shared");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule